// File: doc/BRIEF.md
# Dual-Channel Serial Wiper Register Controller

This block is the digital core of a two-channel, 256-step digitally controlled resistor. A host writes it over a four-wire serial port made of an active-low chip select, a serial clock, a serial data input and a serial data output. Each write is a 9-bit word: one channel-select bit first, then eight data bits, most significant first. When chip select returns high, the last nine bits received are decoded. The select bit picks one of two 8-bit wiper registers, and the data bits are written into that register only. The other register keeps its value.

All serial pins are brought into one system clock domain through synchronizers. Serial clock and chip-select edges are detected there, so the serial clock must run at least four times slower than the system clock. The serial output repeats each bit eight shifts after it came in, which lets several devices share one data line in a chain.

A level-sensitive preset input forces both wipers to half scale and clears the serial-output latch. Preset wins over a load that arrives in the same cycle. Reset also starts both wipers at half scale. A shutdown input drives the two analog switch controls, which open the A terminals and tie the wiper to B. Shutdown also turns off the serial-output driver. The wiper registers keep their values during shutdown, so the old settings return when shutdown ends.

Top module: `dual_wiper_ctrl`

## Requirements
- R1: While chip select is low, each rising serial clock edge shifts one serial-input bit into a 9-bit register. The word is sent channel-select bit first, then data bits D7 down to D0.
- R2: While chip select is high, serial clock edges leave the shift register unchanged. A later chip-select pulse with no clocks in it reloads the same word.
- R3: When chip select rises, only the last nine bits shifted in are used. Any bits shifted in before them have no effect.
- R4: When chip select rises, a select bit of 0 writes the data into wiper 1 and a select bit of 1 writes it into wiper 2. The other wiper does not change.
- R5: After each shift, the serial output shows the bit that was shifted in eight shifts earlier. The shift register starts at all zeros after reset.
- R6: While preset is low, both wipers read 0x80 and the serial-output latch reads 0.
- R7: A chip-select rise that arrives while preset is low loads nothing. Both wipers stay at 0x80 after preset is released.
- R8: After reset, both wipers read 0x80, the serial output reads 0, the A-open and wiper-to-B controls are 0, and the serial-output enable is 1.
- R9: While shutdown is low, the A-open and wiper-to-B controls are 1, the serial-output enable is 0 and the serial output is held at 0. The wiper values are not disturbed, and all three controls return to normal once shutdown goes high.
- R10: A new wiper value appears on the third system-clock rising edge after chip select rises at the pin, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| sdi | input | 1 | Serial data input |
| preset_n | input | 1 | Active-low half-scale preset |
| shdn_n | input | 1 | Active-low shutdown |
| sdo | output | 1 | Serial data output for chaining (0 when disabled) |
| sdo_oe | output | 1 | Serial output driver enable |
| a_open | output | 1 | Opens all A terminals |
| w_to_b | output | 1 | Ties each wiper to its B terminal |
| wiper1 | output | 8 | Wiper 1 setting |
| wiper2 | output | 8 | Wiper 2 setting |

## Verification
Faults in the shift path show up at the serial output within one serial bit, because that output tracks a bit from eight shifts back. Faults in the address decode or word framing show up on the wrong wiper bus three system clocks after chip select rises. A preset or shutdown input that is ignored, or a shutdown that corrupts the registers, is visible within two to three system clocks on the wiper buses and the switch controls. The sweep writes every data value to both channels, so a stuck or swapped data bit, or a select bit that reaches both channels, changes a bus the bench compares after each load.

// File: rtl/dw_pkg.sv
package dw_pkg;
  localparam int DATA_W      = 8;
  localparam int ADDR_W      = 1;
  localparam int WORD_W      = DATA_W + ADDR_W;
  localparam int NUM_CH      = 1 << ADDR_W;
  localparam int SDO_TAP     = 8;
  localparam int SYNC_STAGES = 2;
  typedef logic [DATA_W-1:0] wiper_t;
  localparam wiper_t MIDSCALE = wiper_t'(1 << (DATA_W-1));
endpackage

// File: rtl/dw_sync.sv
module dw_sync #(
  parameter int             WIDTH   = 1,
  parameter int             STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg_q [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      logic [WIDTH-1:0] stg_d;
      if (i == 0) begin : g_first
        assign stg_d = d;
      end else begin : g_next
        assign stg_d = stg_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= RST_VAL;
        else        stg_q[i] <= stg_d;
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/dw_shift.sv
module dw_shift #(
  parameter int WORD_W = 9,
  parameter int TAP    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              din,
  input  logic              clr_sdo,
  output logic [WORD_W-1:0] word,
  output logic              sdo_q
);
  logic [WORD_W-1:0] sr_q, sr_d;
  logic              sdo_d;

  always_comb begin
    sr_d  = sr_q;
    sdo_d = sdo_q;
    if (shift_en) begin
      sr_d  = {sr_q[WORD_W-2:0], din};
      sdo_d = sr_q[TAP-1];
    end
    if (clr_sdo) sdo_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      sdo_q <= 1'b0;
    end else begin
      sr_q  <= sr_d;
      sdo_q <= sdo_d;
    end
  end

  assign word = sr_q;
endmodule

// File: rtl/dw_wipers.sv
module dw_wipers #(
  parameter int          DATA_W = 8,
  parameter int          ADDR_W = 1,
  parameter int          NUM_CH = 2,
  parameter logic [DATA_W-1:0] MID = 8'h80
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        data,
  input  logic                     preset,
  output logic [NUM_CH*DATA_W-1:0] wipers
);
  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      logic [DATA_W-1:0] w_q, w_d;
      logic              sel;
      assign sel = load && (addr == ADDR_W'(c));
      always_comb begin
        w_d = w_q;
        if (sel)    w_d = data;
        if (preset) w_d = MID;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= MID;
        else        w_q <= w_d;
      end
      assign wipers[c*DATA_W +: DATA_W] = w_q;
    end
  endgenerate
endmodule

// File: rtl/dual_wiper_ctrl.sv
module dual_wiper_ctrl
  import dw_pkg::*;
#(
  parameter int STAGES = SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              preset_n,
  input  logic              shdn_n,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              a_open,
  output logic              w_to_b,
  output logic [DATA_W-1:0] wiper1,
  output logic [DATA_W-1:0] wiper2
);
  localparam int NIN = 5;

  logic [NIN-1:0] pins, pins_s;
  logic cs_s, sclk_s, sdi_s, preset_s, shdn_s;
  logic cs_prev_q, cs_prev_d, sclk_prev_q, sclk_prev_d;
  logic cs_rise, sclk_rise, shift_en, load, sdo_q;
  logic [WORD_W-1:0]        sr_word;
  logic [NUM_CH*DATA_W-1:0] wbus;

  assign pins = {preset_n, shdn_n, sdi, sclk, cs_n};

  dw_sync #(.WIDTH(NIN), .STAGES(STAGES), .RST_VAL(5'b11001)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins), .q(pins_s)
  );

  assign {preset_s, shdn_s, sdi_s, sclk_s, cs_s} = pins_s;

  always_comb begin
    cs_prev_d   = cs_s;
    sclk_prev_d = sclk_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev_q   <= 1'b1;
      sclk_prev_q <= 1'b0;
    end else begin
      cs_prev_q   <= cs_prev_d;
      sclk_prev_q <= sclk_prev_d;
    end
  end

  assign cs_rise   = cs_s && !cs_prev_q;
  assign sclk_rise = sclk_s && !sclk_prev_q;
  assign shift_en  = sclk_rise && !cs_s;
  assign load      = cs_rise;

  dw_shift #(.WORD_W(WORD_W), .TAP(SDO_TAP)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .din(sdi_s),
    .clr_sdo(!preset_s), .word(sr_word), .sdo_q(sdo_q)
  );

  dw_wipers #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .MID(MIDSCALE)) u_wipers (
    .clk(clk), .rst_n(rst_n), .load(load),
    .addr(sr_word[WORD_W-1 -: ADDR_W]), .data(sr_word[DATA_W-1:0]),
    .preset(!preset_s), .wipers(wbus)
  );

  assign wiper1 = wbus[0 +: DATA_W];
  assign wiper2 = wbus[DATA_W +: DATA_W];
  assign a_open = !shdn_s;
  assign w_to_b = !shdn_s;
  assign sdo_oe = shdn_s;
  assign sdo    = sdo_q && shdn_s;
endmodule

// File: rtl/dw_checker.sv
module dw_checker
  import dw_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cs_s,
  input logic              cs_rise,
  input logic              sclk_rise,
  input logic              preset_s,
  input logic              shdn_s,
  input logic [WORD_W-1:0] sr_word,
  input logic [DATA_W-1:0] wiper1,
  input logic [DATA_W-1:0] wiper2,
  input logic              sdo,
  input logic              sdo_oe,
  input logic              a_open,
  input logic              w_to_b
);
  p_cs_high_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> $stable(sr_word));

  p_one_channel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    preset_s |=> ($stable(wiper1) || $stable(wiper2)));

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (preset_s && !cs_rise) |=> ($stable(wiper1) && $stable(wiper2)));

  p_sdo_tap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && !cs_s && preset_s && shdn_s) |=> (sdo == $past(sr_word[SDO_TAP-1])));

  p_preset_mid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !preset_s |=> (wiper1 == MIDSCALE && wiper2 == MIDSCALE && !sdo));

  p_preset_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!preset_s && cs_rise) |=> (wiper1 == MIDSCALE && wiper2 == MIDSCALE));

  p_shutdown_ctrl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_s |-> (a_open && w_to_b && !sdo_oe && !sdo));

  p_shutdown_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!shdn_s && preset_s && !cs_rise) |=> ($stable(wiper1) && $stable(wiper2)));
endmodule

bind dual_wiper_ctrl dw_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .cs_rise(cs_rise),
  .sclk_rise(sclk_rise), .preset_s(preset_s), .shdn_s(shdn_s),
  .sr_word(sr_word), .wiper1(wiper1), .wiper2(wiper2), .sdo(sdo),
  .sdo_oe(sdo_oe), .a_open(a_open), .w_to_b(w_to_b)
);

// File: tb/dual_wiper_ctrl_test.sv
`timescale 1ns/1ps
module dual_wiper_ctrl_test;
  logic clk = 1'b0;
  logic rst_n, cs_n, sclk, sdi, preset_n, shdn_n;
  logic sdo, sdo_oe, a_open, w_to_b;
  logic [7:0] wiper1, wiper2;

  int checks = 0;
  int fails  = 0;
  logic [7:0]  m1, m2;
  logic [15:0] hist;
  logic        exp_sdo;

  always #2.5 clk = ~clk;

  dual_wiper_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .preset_n(preset_n), .shdn_n(shdn_n), .sdo(sdo), .sdo_oe(sdo_oe),
    .a_open(a_open), .w_to_b(w_to_b), .wiper1(wiper1), .wiper2(wiper2)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    sdi  = b;
    sclk = 1'b0;
    step(4);
    sclk = 1'b1;
    step(4);
    hist    = {hist[14:0], b};
    exp_sdo = preset_n ? hist[8] : 1'b0;
    check("R5 sdo tap", {7'd0, sdo}, {7'd0, exp_sdo & shdn_n});
    sclk = 1'b0;
  endtask

  task automatic send_bits(input logic [15:0] bits, input int n, input bit chk_lat,
                           input logic [7:0] new1, input logic [7:0] new2);
    cs_n = 1'b0;
    step(4);
    for (int i = n - 1; i >= 0; i--) shift_bit(bits[i]);
    step(2);
    cs_n = 1'b1;
    if (chk_lat) begin
      step(2);
      check("R10 not before third edge w1", wiper1, m1);
      check("R10 not before third edge w2", wiper2, m2);
      step(1);
    end else begin
      step(3);
    end
    m1 = new1;
    m2 = new2;
    step(3);
  endtask

  task automatic write_word(input logic a, input logic [7:0] d, input bit chk_lat);
    send_bits({7'd0, a, d}, 9, chk_lat, a ? m1 : d, a ? d : m2);
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0;
    preset_n = 1'b1; shdn_n = 1'b1;
    hist = '0; exp_sdo = 1'b0;
    m1 = 8'h80; m2 = 8'h80;
    step(3);
    rst_n = 1'b1;
    step(3);

    // R8 reset state
    check("R8 wiper1 reset", wiper1, 8'h80);
    check("R8 wiper2 reset", wiper2, 8'h80);
    check("R8 sdo reset", {7'd0, sdo}, 8'd0);
    check("R8 controls reset", {5'd0, a_open, w_to_b, sdo_oe}, 8'b001);

    // R1 R4 R10 sweep over both channels and all data values
    for (int a = 0; a < 2; a++) begin
      for (int d = 0; d < 256; d++) begin
        write_word(a[0], d[7:0], (d % 32) == 0);
        check("R4 wiper1 after load", wiper1, m1);
        check("R1 wiper2 after load", wiper2, m2);
      end
    end

    // R3 extra leading bits ignored: 4 junk bits then select 1, data 3C
    send_bits({3'd0, 4'b1011, 1'b1, 8'h3C}, 13, 1'b0, m1, 8'h3C);
    check("R3 wiper2 last nine bits", wiper2, 8'h3C);
    check("R3 wiper1 untouched", wiper1, m1);
    send_bits({4'd0, 3'b111, 1'b0, 8'h5A}, 12, 1'b0, 8'h5A, m2);
    check("R3 wiper1 last nine bits", wiper1, 8'h5A);

    // R2 clocks with chip select high are ignored
    for (int i = 0; i < 12; i++) begin
      sdi = 1'b1; sclk = 1'b1; step(4);
      sclk = 1'b0; step(4);
    end
    cs_n = 1'b0; step(4);
    cs_n = 1'b1; step(6);
    check("R2 wiper1 unchanged", wiper1, 8'h5A);
    check("R2 wiper2 unchanged", wiper2, 8'h3C);

    // R6 preset, R7 preset priority over load
    write_word(1'b0, 8'h11, 1'b0);
    preset_n = 1'b0;
    exp_sdo  = 1'b0;
    step(4);
    check("R6 wiper1 preset", wiper1, 8'h80);
    check("R6 wiper2 preset", wiper2, 8'h80);
    check("R6 sdo cleared", {7'd0, sdo}, 8'd0);
    m1 = 8'h80; m2 = 8'h80;
    send_bits({7'd0, 1'b0, 8'h55}, 9, 1'b0, 8'h80, 8'h80);
    preset_n = 1'b1;
    step(4);
    check("R7 wiper1 after preset load", wiper1, 8'h80);
    check("R7 wiper2 after preset load", wiper2, 8'h80);
    check("R6 sdo after release", {7'd0, sdo}, 8'd0);

    // R9 shutdown keeps settings
    write_word(1'b0, 8'h21, 1'b0);
    write_word(1'b1, 8'hE7, 1'b0);
    shdn_n = 1'b0;
    step(4);
    check("R9 controls in shutdown", {5'd0, a_open, w_to_b, sdo_oe}, 8'b110);
    check("R9 sdo in shutdown", {7'd0, sdo}, 8'd0);
    check("R9 wiper1 kept", wiper1, 8'h21);
    check("R9 wiper2 kept", wiper2, 8'hE7);
    shdn_n = 1'b1;
    step(4);
    check("R9 controls after shutdown", {5'd0, a_open, w_to_b, sdo_oe}, 8'b001);
    check("R9 wiper1 restored", wiper1, 8'h21);
    check("R9 wiper2 restored", wiper2, 8'hE7);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #900000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule